// File: doc/BRIEF.md
# Corrected-Block Output Scheduler

This block decides, once per received block period, which corrected data a host processor may read and when. A one-cycle strobe marks the start of each block period, together with the number (1 to the frame length) of the block now arriving, a per-packet flag for the packet that just finished, and the frame-sync status. The packet that just finished is the previous block, or the last block of the previous frame when the strobe carries block 1. The flag is high when horizontal decoding left that packet clean, either because it had no errors or because it was fully repaired. From these inputs the block opens read windows and drives an active-low request line. It reports whether the presented buffer holds horizontally or vertically corrected data, and which packet it holds.

The block keeps a record of each frame as it arrives. At the next frame head it decides whether vertical correction of that frame is worthwhile, and pulses a start signal when it is. During the following frame the vertically corrected packets come out at fixed reception positions, one per block period. Packets that were already clean leave empty slots behind them. The request is not moved earlier to fill those slots. An all-data mode input widens the horizontal stream but leaves the vertical rules untouched.

Top module: `corr_out_sched`

## Requirements
- R1: After reset `req_n` is 1, `pres_blk` is 0, `pres_vert` is 0 and `vc_start` is 0 until the first strobe.
- R2: With `all_mode` at 0, a strobe carrying block b, with `frame_sync` at 1 and `pkt_ok` at 1, presents packet b-1 (the frame length when b is 1) as horizontal data. `pres_vert` is 0 and `req_n` is 0 from the first cycle after the strobe edge.
- R3: With `all_mode` at 0, a strobe with `pkt_ok` at 0 or `frame_sync` at 0 raises no horizontal request in that block period.
- R4: With `all_mode` at 1, every strobe raises a horizontal request for packet b-1, whatever the values of `pkt_ok` and `frame_sync`.
- R5: In a block period outside the vertical output period, the horizontal window lasts LONG_WIN cycles after the strobe edge. Inside the vertical output period, the horizontal window covers cycles 0 to SHORT_WIN-1 and the vertical window covers cycles SHORT_WIN to 2*SHORT_WIN-1, so when both are ready the horizontal block is requested first.
- R6: A `rd_ack` pulse sampled while a window is open sets `req_n` to 1 and `pres_blk` to 0 for the rest of that window, so that only one block is read per request.
- R7: A new strobe arriving while a window is open replaces the presented block from the next cycle on.
- R8: Vertical output is enabled for frame n+1, and `vc_start` pulses for one cycle after the head strobe, when three conditions all hold for frame n. Frame n ran from a block-1 strobe through consecutive block numbers up to the frame length. `frame_sync` was 1 at every strobe that stored one of its packets. At least one of its packets had `pkt_ok` at 0.
- R9: No vertical data is offered, and `vc_start` stays 0, after a frame in which every packet was clean, after a frame that lost sync at any strobe, or after the first frame following reset.
- R10: When vertical output is enabled, data packet k (1 to DATA_BLKS) is offered as vertical data (`pres_vert` at 1, `pres_blk` = k) in the block period of reception position VERT_LEAD+k, but only if its flag was 0. A clean packet leaves its slot with no request.
- R11: `all_mode` at 1 does not cause clean packets to be offered in the vertical stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_stb | input | 1 | One-cycle pulse at the start of each received block |
| blk_num | input | BW | Number of the block now being received, 1..FRAME_BLKS |
| frame_sync | input | 1 | Frame synchronization held, sampled with the strobe |
| pkt_ok | input | 1 | Packet just completed was clean after horizontal decoding |
| all_mode | input | 1 | Offer every horizontal block regardless of status |
| rd_ack | input | 1 | Host finished reading the presented block |
| req_n | output | 1 | Active-low transfer request |
| pres_vert | output | 1 | 1 when the vertical buffer is presented |
| pres_blk | output | BW | Packet number presented, 0 when idle |
| vc_start | output | 1 | One-cycle pulse: vertical correction of the last frame begins |

## Verification
Horizontal delivery of the previous packet and vertical delivery of a slot-locked data packet can both fall in the same block period inside reception positions 29 to 218. The bench provokes this by running whole frames with chosen flag patterns, then judges each such period at two sample points: the strobe cycle plus one, and SHORT_WIN cycles later. The expected kind and packet number at each point come from the pattern the bench stored for the previous frame. A host acknowledge and a window boundary, or a new strobe and an open window, are the other pairs that can coincide; directed cases place an acknowledge mid-window and a strobe mid-window and check the lines in the next cycle.

// File: rtl/cos_pkg.sv
package cos_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HORZ = 2'd1,
    SRC_VERT = 2'd2
  } src_e;

  // packet completed when block b starts arriving
  function automatic int unsigned horz_pkt(input int unsigned b,
                                           input int unsigned frame_blks);
    return (b == 1) ? frame_blks : b - 1;
  endfunction

  // does reception position b fall in the vertical output period
  function automatic bit in_vert_slot(input int unsigned b,
                                      input int unsigned lead,
                                      input int unsigned data_blks);
    return (b > lead) && (b <= lead + data_blks);
  endfunction

  // data packet offered vertically at reception position b
  function automatic int unsigned vert_pkt(input int unsigned b,
                                           input int unsigned lead);
    return b - lead;
  endfunction

endpackage

// File: rtl/cos_frame_ledger.sv
module cos_frame_ledger #(
  parameter int FRAME_BLKS = 272,
  parameter int DATA_BLKS  = 190,
  parameter int BW         = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stb,
  input  logic [BW-1:0]        blk_num,
  input  logic                 frame_sync,
  input  logic                 pkt_ok,
  output logic                 vert_en,
  output logic [DATA_BLKS-1:0] vmap,
  output logic                 vstart,
  output logic                 head_evt
);
  localparam int MW = (DATA_BLKS > 1) ? $clog2(DATA_BLKS) : 1;
  localparam logic [BW-1:0] ONE_B  = BW'(1);
  localparam logic [BW-1:0] FRM_B  = BW'(FRAME_BLKS);
  localparam logic [BW-1:0] DATA_B = BW'(DATA_BLKS);

  logic                 in_frame, seq_ok, sync_all, fix_all;
  logic [BW-1:0]        prev_b;
  logic [DATA_BLKS-1:0] cur_map;
  logic [BW-1:0]        done_pkt;
  logic                 frame_full, go_vert, store_bit;

  assign head_evt   = stb && (blk_num == ONE_B);
  assign done_pkt   = blk_num - ONE_B;
  assign store_bit  = stb && !head_evt && (done_pkt >= ONE_B) && (done_pkt <= DATA_B);
  assign frame_full = in_frame && seq_ok && (prev_b == FRM_B);
  assign go_vert    = frame_full && sync_all && frame_sync && !(fix_all && pkt_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      seq_ok   <= 1'b0;
      sync_all <= 1'b0;
      fix_all  <= 1'b0;
      prev_b   <= '0;
      cur_map  <= '0;
      vmap     <= '0;
      vert_en  <= 1'b0;
      vstart   <= 1'b0;
    end else begin
      vstart <= 1'b0;
      if (head_evt) begin
        vert_en  <= go_vert;
        vstart   <= go_vert;
        vmap     <= cur_map;
        cur_map  <= '0;
        in_frame <= 1'b1;
        seq_ok   <= 1'b1;
        sync_all <= 1'b1;
        fix_all  <= 1'b1;
      end else if (stb) begin
        seq_ok   <= seq_ok && (blk_num == prev_b + ONE_B);
        sync_all <= sync_all && frame_sync;
        fix_all  <= fix_all && pkt_ok;
        if (store_bit) cur_map[MW'(done_pkt - ONE_B)] <= pkt_ok;
      end
      if (stb) prev_b <= blk_num;
    end
  end

endmodule

// File: rtl/cos_slot_decide.sv
module cos_slot_decide
  import cos_pkg::*;
#(
  parameter int FRAME_BLKS = 272,
  parameter int DATA_BLKS  = 190,
  parameter int VERT_LEAD  = 28,
  parameter int BW         = 9
) (
  input  logic [BW-1:0]        blk_num,
  input  logic                 frame_sync,
  input  logic                 pkt_ok,
  input  logic                 all_mode,
  input  logic                 vert_en,
  input  logic [DATA_BLKS-1:0] vmap,
  output logic                 h_want,
  output logic [BW-1:0]        h_blk,
  output logic                 v_want,
  output logic [BW-1:0]        v_blk,
  output logic                 dual
);
  localparam int MW = (DATA_BLKS > 1) ? $clog2(DATA_BLKS) : 1;

  logic          in_v;
  logic [BW-1:0] k_raw;
  logic [MW-1:0] k_idx;

  always_comb begin
    in_v   = in_vert_slot(32'(blk_num), VERT_LEAD, DATA_BLKS);
    k_raw  = BW'(vert_pkt(32'(blk_num), VERT_LEAD));
    k_idx  = in_v ? MW'(k_raw - BW'(1)) : '0;
    dual   = vert_en && in_v;
    v_want = dual && !vmap[k_idx];
    v_blk  = dual ? k_raw : '0;
    h_blk  = BW'(horz_pkt(32'(blk_num), FRAME_BLKS));
    h_want = all_mode || (frame_sync && pkt_ok);
  end

endmodule

// File: rtl/cos_req_window.sv
module cos_req_window
  import cos_pkg::*;
#(
  parameter int SHORT_WIN = 16,
  parameter int LONG_WIN  = 32,
  parameter int BW        = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          h_want,
  input  logic [BW-1:0] h_blk,
  input  logic          v_want,
  input  logic [BW-1:0] v_blk,
  input  logic          dual,
  input  logic          rd_ack,
  output logic          req_n,
  output logic          pres_vert,
  output logic [BW-1:0] pres_blk,
  output logic          h_win,
  output logic          v_win
);
  localparam int TMAX = (LONG_WIN > 2*SHORT_WIN) ? LONG_WIN : 2*SHORT_WIN;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] SHORT_T  = TW'(SHORT_WIN);
  localparam logic [TW-1:0] SHORT2_T = TW'(2*SHORT_WIN);
  localparam logic [TW-1:0] LONG_T   = TW'(LONG_WIN);
  localparam logic [TW-1:0] TMAX_T   = TW'(TMAX);

  logic [TW-1:0] slot_cnt;
  logic          h_act, v_act, dual_q, h_done, v_done;
  logic [BW-1:0] h_blk_q, v_blk_q;
  logic [TW-1:0] h_lim;
  src_e          src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_cnt <= TMAX_T;
      h_act    <= 1'b0;
      v_act    <= 1'b0;
      dual_q   <= 1'b0;
      h_done   <= 1'b0;
      v_done   <= 1'b0;
      h_blk_q  <= '0;
      v_blk_q  <= '0;
    end else if (stb) begin
      slot_cnt <= '0;
      h_act    <= h_want;
      v_act    <= v_want;
      dual_q   <= dual;
      h_blk_q  <= h_blk;
      v_blk_q  <= v_blk;
      h_done   <= 1'b0;
      v_done   <= 1'b0;
    end else begin
      if (slot_cnt != TMAX_T) slot_cnt <= slot_cnt + TW'(1);
      if (rd_ack && h_win) h_done <= 1'b1;
      if (rd_ack && v_win) v_done <= 1'b1;
    end
  end

  always_comb begin
    h_lim = dual_q ? SHORT_T : LONG_T;
    h_win = h_act && !h_done && (slot_cnt < h_lim);
    v_win = v_act && !v_done && (slot_cnt >= SHORT_T) && (slot_cnt < SHORT2_T);
    if (v_win)      src = SRC_VERT;
    else if (h_win) src = SRC_HORZ;
    else            src = SRC_NONE;
    req_n     = (src == SRC_NONE);
    pres_vert = (src == SRC_VERT);
    case (src)
      SRC_VERT: pres_blk = v_blk_q;
      SRC_HORZ: pres_blk = h_blk_q;
      default:  pres_blk = '0;
    endcase
  end

endmodule

// File: rtl/corr_out_sched.sv
module corr_out_sched #(
  parameter int FRAME_BLKS = 272,
  parameter int DATA_BLKS  = 190,
  parameter int VERT_LEAD  = 28,
  parameter int SHORT_WIN  = 16,
  parameter int LONG_WIN   = 32,
  localparam int BW        = $clog2(FRAME_BLKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_stb,
  input  logic [BW-1:0] blk_num,
  input  logic          frame_sync,
  input  logic          pkt_ok,
  input  logic          all_mode,
  input  logic          rd_ack,
  output logic          req_n,
  output logic          pres_vert,
  output logic [BW-1:0] pres_blk,
  output logic          vc_start
);
  logic                 vert_en;
  logic [DATA_BLKS-1:0] vmap;
  logic                 head_evt;
  logic                 h_want, v_want, dual;
  logic [BW-1:0]        h_blk, v_blk;
  logic                 h_win, v_win;

  cos_frame_ledger #(
    .FRAME_BLKS(FRAME_BLKS), .DATA_BLKS(DATA_BLKS), .BW(BW)
  ) u_ledger (
    .clk(clk), .rst_n(rst_n), .stb(blk_stb), .blk_num(blk_num),
    .frame_sync(frame_sync), .pkt_ok(pkt_ok),
    .vert_en(vert_en), .vmap(vmap), .vstart(vc_start), .head_evt(head_evt)
  );

  cos_slot_decide #(
    .FRAME_BLKS(FRAME_BLKS), .DATA_BLKS(DATA_BLKS),
    .VERT_LEAD(VERT_LEAD), .BW(BW)
  ) u_decide (
    .blk_num(blk_num), .frame_sync(frame_sync), .pkt_ok(pkt_ok),
    .all_mode(all_mode), .vert_en(vert_en), .vmap(vmap),
    .h_want(h_want), .h_blk(h_blk), .v_want(v_want), .v_blk(v_blk),
    .dual(dual)
  );

  cos_req_window #(
    .SHORT_WIN(SHORT_WIN), .LONG_WIN(LONG_WIN), .BW(BW)
  ) u_window (
    .clk(clk), .rst_n(rst_n), .stb(blk_stb),
    .h_want(h_want), .h_blk(h_blk), .v_want(v_want), .v_blk(v_blk),
    .dual(dual), .rd_ack(rd_ack),
    .req_n(req_n), .pres_vert(pres_vert), .pres_blk(pres_blk),
    .h_win(h_win), .v_win(v_win)
  );

endmodule

// File: rtl/cos_sched_chk.sv
module cos_sched_chk #(
  parameter int FRAME_BLKS = 272,
  parameter int VERT_LEAD  = 28,
  parameter int SHORT_WIN  = 16,
  parameter int LONG_WIN   = 32,
  parameter int BW         = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          blk_stb,
  input logic [BW-1:0] blk_num,
  input logic          rd_ack,
  input logic          req_n,
  input logic          pres_vert,
  input logic [BW-1:0] pres_blk,
  input logic          vc_start,
  input logic          vert_en,
  input logic          h_win,
  input logic          v_win
);
  localparam int TMAX = (LONG_WIN > 2*SHORT_WIN) ? LONG_WIN : 2*SHORT_WIN;
  localparam int CW   = $clog2(TMAX + 2);

  logic [BW-1:0] last_b;
  logic [CW-1:0] since;
  logic [BW-1:0] hexp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_b <= '0;
      since  <= CW'(TMAX + 1);
    end else if (blk_stb) begin
      last_b <= blk_num;
      since  <= '0;
    end else if (since != CW'(TMAX + 1)) begin
      since <= since + CW'(1);
    end
  end

  assign hexp = (last_b == BW'(1)) ? BW'(FRAME_BLKS) : last_b - BW'(1);

  // R2: a horizontal presentation carries the packet before the last strobe
  a_r2_horz_prev: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && !pres_vert) |-> (pres_blk == hexp));

  // R5: no request outlives the longest window after its strobe
  a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !req_n |-> (32'(since) < TMAX));

  // R5: the two windows never overlap
  a_r5_one_window: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({h_win, v_win}) <= 1);

  // R6: acknowledging a vertical block ends the request
  a_r6_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && pres_vert && rd_ack && !blk_stb) |=> req_n);

  // R8: the start pulse follows only a head strobe
  a_r8_vc_head: assert property (@(posedge clk) disable iff (!rst_n)
    vc_start |-> ($past(blk_stb) && ($past(blk_num) == BW'(1))));

  // R9: vertical data only while the ledger enabled it
  a_r9_vert_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && pres_vert) |-> vert_en);

  // R10: vertical packet is locked to its reception slot
  a_r10_vert_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && pres_vert) |-> ((pres_blk != '0) &&
                               (32'(pres_blk) + VERT_LEAD == 32'(last_b))));

endmodule

bind corr_out_sched cos_sched_chk #(
  .FRAME_BLKS(FRAME_BLKS), .VERT_LEAD(VERT_LEAD),
  .SHORT_WIN(SHORT_WIN), .LONG_WIN(LONG_WIN), .BW(BW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_stb(blk_stb), .blk_num(blk_num),
  .rd_ack(rd_ack), .req_n(req_n), .pres_vert(pres_vert),
  .pres_blk(pres_blk), .vc_start(vc_start), .vert_en(vert_en),
  .h_win(h_win), .v_win(v_win)
);

// File: tb/corr_out_sched_bench.sv
module corr_out_sched_bench;
  localparam int FRAME  = 272;
  localparam int DATA   = 190;
  localparam int LEAD   = 28;
  localparam int SHORT  = 16;
  localparam int LONG   = 32;
  localparam int PERIOD = 40;
  localparam int BW     = $clog2(FRAME + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          blk_stb = 1'b0;
  logic [BW-1:0] blk_num = '0;
  logic          frame_sync = 1'b0;
  logic          pkt_ok = 1'b0;
  logic          all_mode = 1'b0;
  logic          rd_ack = 1'b0;
  logic          req_n;
  logic          pres_vert;
  logic [BW-1:0] pres_blk;
  logic          vc_start;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;
  bit prev_fix [1:DATA];
  bit cur_fix  [1:DATA];

  always #2.5 clk = ~clk;

  corr_out_sched u_corr_out_sched (
    .clk(clk), .rst_n(rst_n), .blk_stb(blk_stb), .blk_num(blk_num),
    .frame_sync(frame_sync), .pkt_ok(pkt_ok), .all_mode(all_mode),
    .rd_ack(rd_ack), .req_n(req_n), .pres_vert(pres_vert),
    .pres_blk(pres_blk), .vc_start(vc_start)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; blk_stb = 1'b0; rd_ack = 1'b0; all_mode = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // strobe; returns at the first cycle after the capturing edge
  task automatic strobe(input int b, input bit sync, input bit ok, input bit amode);
    @(negedge clk);
    blk_num = BW'(b); frame_sync = sync; pkt_ok = ok; all_mode = amode;
    blk_stb = 1'b1;
    @(negedge clk);
    blk_stb = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_idle(input string tag);
    chk(req_n == 1'b1, tag, int'(req_n), 1);
    chk(pres_blk == '0, tag, int'(pres_blk), 0);
  endtask

  task automatic expect_pres(input string tag, input bit vert, input int blk);
    chk(req_n == 1'b0, tag, int'(req_n), 0);
    chk(pres_vert == vert, tag, int'(pres_vert), int'(vert));
    chk(int'(pres_blk) == blk, tag, int'(pres_blk), blk);
  endtask

  task automatic t_reset_state();
    expect_idle("R1 reset");
    chk(vc_start == 1'b0, "R1 reset vc_start", int'(vc_start), 0);
    chk(pres_vert == 1'b0, "R1 reset pres_vert", int'(pres_vert), 0);
  endtask

  task automatic t_horz_long();
    strobe(5, 1, 1, 0);
    expect_pres("R2 horizontal packet b-1", 0, 4);
    wait_n(LONG - 1);
    chk(req_n == 1'b0, "R5 long window last cycle", int'(req_n), 0);
    wait_n(1);
    chk(req_n == 1'b1, "R5 long window closed", int'(req_n), 1);
    wait_n(4);
  endtask

  task automatic t_suppress_and_all();
    strobe(7, 1, 0, 0);
    expect_idle("R3 not clean");
    strobe(8, 0, 1, 0);
    expect_idle("R3 no sync");
    strobe(9, 0, 0, 1);
    expect_pres("R4 all mode", 0, 8);
    wait_n(LONG + 2);
  endtask

  task automatic t_ack();
    strobe(12, 1, 1, 0);
    wait_n(2);
    expect_pres("R6 before ack", 0, 11);
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    expect_idle("R6 after ack");
    wait_n(5);
    expect_idle("R6 stays released");
    wait_n(LONG);
  endtask

  task automatic t_overwrite();
    strobe(20, 1, 1, 0);
    wait_n(5);
    expect_pres("R7 first block", 0, 19);
    strobe(21, 1, 1, 0);
    expect_pres("R7 overwritten", 0, 20);
    wait_n(LONG + 2);
  endtask

  task automatic t_head_wrap();
    strobe(1, 1, 1, 0);
    expect_pres("R2 head wraps to last packet", 0, FRAME);
    chk(vc_start == 1'b0, "R9 no start without full frame", int'(vc_start), 0);
    wait_n(LONG + 2);
  endtask

  function automatic bit fixpat(input int fid, input int k);
    case (fid)
      0: return (k % 4) != 0;
      2: return (k % 5) != 0;
      3: return (k % 3) != 0;
      default: return 1'b1;
    endcase
  endfunction

  // one whole frame; exp_vert says whether the previous frame qualifies
  task automatic run_frame(input int fid, input bit exp_vert, input int drop_b,
                           input bit allfix, input bit amode);
    for (int b = 1; b <= FRAME; b++) begin
      int  pkt;
      bit  fix, sync, exp_h, dual, exp_v;
      int  k;
      string tagv;
      pkt  = (b == 1) ? FRAME : b - 1;
      fix  = (b == 1 || pkt > DATA) ? 1'b1 : (allfix ? 1'b1 : fixpat(fid, pkt));
      sync = (b != drop_b);
      exp_h = amode || (sync && fix);
      dual  = exp_vert && (b > LEAD) && (b <= LEAD + DATA);
      k     = b - LEAD;
      exp_v = dual && !prev_fix[k];
      if (b >= 2 && pkt <= DATA) cur_fix[pkt] = fix;
      strobe(b, sync, fix, amode);
      if (b == 1)
        chk(vc_start == exp_vert, exp_vert ? "R8 start pulse" : "R9 no start pulse",
            int'(vc_start), int'(exp_vert));
      if (exp_h) expect_pres(amode ? "R4 horizontal" : "R2 horizontal", 0, pkt);
      else       expect_idle("R3 horizontal suppressed");
      wait_n(SHORT);
      if (exp_v) begin
        tagv = amode ? "R11 vertical slot" : "R10 vertical slot";
        expect_pres(tagv, 1, k);
      end else if (exp_h && !dual) begin
        expect_pres("R5 single window still open", 0, pkt);
      end else begin
        tagv = dual ? (amode ? "R11 clean packet gap" : "R10 clean packet gap")
                    : "R9 no vertical";
        expect_idle(tagv);
      end
      wait_n(PERIOD - 2 - SHORT);
    end
    for (int k = 1; k <= DATA; k++) prev_fix[k] = cur_fix[k];
  endtask

  initial begin
    for (int k = 1; k <= DATA; k++) begin
      prev_fix[k] = 1'b1;
      cur_fix[k]  = 1'b1;
    end
    do_reset();
    t_reset_state();
    t_horz_long();
    t_suppress_and_all();
    t_ack();
    t_overwrite();
    t_head_wrap();

    do_reset();
    t_reset_state();
    run_frame(0, 1'b0, 0, 1'b0, 1'b0);   // first frame: nothing earlier
    run_frame(1, 1'b1, 0, 1'b1, 1'b0);   // frame 0 partly clean -> R8/R10
    run_frame(2, 1'b0, 100, 1'b0, 1'b0); // frame 1 all clean -> R9
    run_frame(3, 1'b0, 0, 1'b0, 1'b1);   // frame 2 lost sync -> R9
    run_frame(4, 1'b1, 0, 1'b1, 1'b1);   // all mode keeps gaps -> R11
    summary();
  end

endmodule